// File: doc/BRIEF.md
# Flow Directory Lookup

This block finds the flow record that belongs to an incoming packet. For each packet it gets two precomputed hashes of the flow key. The short hash is an index into an on-chip directory. The wide hash is a check value that confirms the flow. Each directory slot holds a valid flag, a record pointer and the stored check value. The flow records themselves are kept in a separate memory that this block never touches. The directory only points into it.

When a valid slot holds the same check value, the block returns that slot's pointer so the caller can update the record. When the slot is empty, the block requests a free pointer from an external record allocator, installs the new slot and reports a new flow. A valid slot with a different check value is reported as a collision and is left as it is. An allocator refusal is reported as a table-full drop and nothing is written. A record manager can release a slot through a separate invalidate input.

A lookup always takes the same number of directory accesses, because a match is decided from one wide compare and never from the full key. Only one key is in flight at a time. Keys use a valid/ready handshake, responses use a valid/ready handshake, and allocations use a request/acknowledge pair.

Top module: `flow_dir_lookup`

## Requirements
- R1: After a synchronous active-high reset, key_ready is 1, rsp_valid is 0 and alloc_req is 0. Every slot is invalid, so the first lookup of any index is handled as a new flow.
- R2: A key is taken in a cycle where key_valid and key_ready are both 1. key_ready then stays 0 until the response has been taken with rsp_ready, and it returns to 1 in the cycle after that.
- R3: A lookup that hits an invalid slot raises alloc_req. On an acknowledge with alloc_full = 0, the block stores alloc_ptr and the key's check hash in the slot and responds with kind NEW (2'd1) and rsp_ptr = alloc_ptr.
- R4: A lookup whose slot is valid and holds the same check hash responds with kind HIT (2'd0) and the stored pointer, without raising alloc_req.
- R5: A lookup whose slot is valid but holds a different check hash responds with kind COLLIDE (2'd2) and rsp_ptr = 0. The slot keeps its old contents, so a later lookup with the original check hash still hits the original pointer.
- R6: When the allocator acknowledges with alloc_full = 1, the response is kind FULL (2'd3) with rsp_ptr = 0 and the slot stays invalid. A repeat of the same key then requests allocation again.
- R7: A one-cycle pulse on inv_valid clears the slot at inv_idx. The next lookup of that index is a new flow, and other slots are not affected.
- R8: alloc_req stays high until alloc_ack. rsp_valid, rsp_kind and rsp_ptr stay stable until rsp_ready is seen.
- R9: All CHK_W bits take part in the compare. A check hash that differs from the stored one only in its most significant bit is a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | A key with its hashes is offered |
| key_ready | output | 1 | Block is idle and takes a key |
| key_idx | input | IDX_W | Short hash, the slot index |
| key_chk | input | CHK_W | Wide check hash |
| rsp_valid | output | 1 | Response is available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_kind | output | 2 | 0 HIT, 1 NEW, 2 COLLIDE, 3 FULL |
| rsp_ptr | output | PTR_W | Record pointer for HIT or NEW, 0 otherwise |
| alloc_req | output | 1 | Request for a free record pointer |
| alloc_ack | input | 1 | Allocator answers the request |
| alloc_full | input | 1 | With alloc_ack: no record is free |
| alloc_ptr | input | PTR_W | With alloc_ack: the granted pointer |
| inv_valid | input | 1 | Clear one slot |
| inv_idx | input | IDX_W | Index of the slot to clear |

## Verification
The lookup path is driven with repeated keys to separate hits from new installs. The same index is also driven with a different check hash, including one that differs only in its top bit, which separates a collision from a hit and shows that the slot is not overwritten. Allocator refusals are followed by a retry of the same key, which shows that a refused install writes nothing. Invalidations and a mid-run reset are each followed by lookups of both the cleared index and a neighbouring index, which tells a targeted clear apart from a global one. A response held back by rsp_ready shows whether the outputs stay stable and whether new keys stay blocked.

// File: rtl/flow_dir_pkg.sv
package flow_dir_pkg;
  typedef enum logic [1:0] {
    FLOW_HIT     = 2'd0,
    FLOW_NEW     = 2'd1,
    FLOW_COLLIDE = 2'd2,
    FLOW_FULL    = 2'd3
  } flow_rsp_e;
endpackage

// File: rtl/flow_dir_ram.sv
// Simple dual-port directory storage, synchronous read, block RAM style.
module flow_dir_ram #(
  parameter int AW = 8,
  parameter int DW = 61
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/flow_dir_valid.sv
// Per-slot valid flags in flops so reset and invalidation are single-cycle.
module flow_dir_valid #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx,
  input  logic [AW-1:0] q_idx,
  output logic          q_valid
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] vbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits <= '0;
    end else begin
      if (set_en) vbits[set_idx] <= 1'b1;
      // a clear of the same slot in the same cycle wins over a set
      if (clr_en) vbits[clr_idx] <= 1'b0;
    end
  end

  assign q_valid = vbits[q_idx];
endmodule

// File: rtl/flow_dir_ctrl.sv
// Lookup sequencer: accept, read slot, decide, optionally allocate, respond.
module flow_dir_ctrl
  import flow_dir_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CHK_W = 45,
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [IDX_W-1:0] key_idx,
  input  logic [CHK_W-1:0] key_chk,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output flow_rsp_e        rsp_kind,
  output logic [PTR_W-1:0] rsp_ptr,
  output logic             alloc_req,
  input  logic             alloc_ack,
  input  logic             alloc_full,
  input  logic [PTR_W-1:0] alloc_ptr,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [CHK_W-1:0] rd_chk,
  input  logic             slot_valid,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [CHK_W-1:0] wr_chk
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_ALLOC, S_RESP} state_e;

  state_e           state;
  logic [IDX_W-1:0] idx_q;
  logic [CHK_W-1:0] chk_q;
  logic             chk_eq;

  assign chk_eq    = (rd_chk == chk_q);
  assign key_ready = (state == S_IDLE);
  assign rd_en     = key_valid && (state == S_IDLE);
  assign rd_idx    = key_idx;
  assign cur_idx   = idx_q;
  assign wr_en     = (state == S_ALLOC) && alloc_ack && !alloc_full;
  assign wr_ptr    = alloc_ptr;
  assign wr_chk    = chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx_q     <= '0;
      chk_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= FLOW_HIT;
      rsp_ptr   <= '0;
      alloc_req <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (key_valid) begin
            idx_q <= key_idx;
            chk_q <= key_chk;
            state <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (slot_valid && chk_eq) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= FLOW_HIT;
            rsp_ptr   <= rd_ptr;
            state     <= S_RESP;
          end else if (slot_valid) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= FLOW_COLLIDE;
            rsp_ptr   <= '0;
            state     <= S_RESP;
          end else begin
            alloc_req <= 1'b1;
            state     <= S_ALLOC;
          end
        end
        S_ALLOC: begin
          if (alloc_ack) begin
            alloc_req <= 1'b0;
            rsp_valid <= 1'b1;
            if (alloc_full) begin
              rsp_kind <= FLOW_FULL;
              rsp_ptr  <= '0;
            end else begin
              rsp_kind <= FLOW_NEW;
              rsp_ptr  <= alloc_ptr;
            end
            state <= S_RESP;
          end
        end
        S_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flow_dir_lookup.sv
module flow_dir_lookup
  import flow_dir_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CHK_W = 45,
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [IDX_W-1:0] key_idx,
  input  logic [CHK_W-1:0] key_chk,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_kind,
  output logic [PTR_W-1:0] rsp_ptr,
  output logic             alloc_req,
  input  logic             alloc_ack,
  input  logic             alloc_full,
  input  logic [PTR_W-1:0] alloc_ptr,
  input  logic             inv_valid,
  input  logic [IDX_W-1:0] inv_idx
);
  localparam int ENTRY_W = PTR_W + CHK_W;

  logic               rd_en;
  logic [IDX_W-1:0]   rd_idx;
  logic [ENTRY_W-1:0] rd_entry;
  logic [IDX_W-1:0]   cur_idx;
  logic               wr_en;
  logic [PTR_W-1:0]   wr_ptr;
  logic [CHK_W-1:0]   wr_chk;
  logic               slot_valid;
  flow_rsp_e          kind;

  assign rsp_kind = kind;

  flow_dir_ram #(.AW(IDX_W), .DW(ENTRY_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (cur_idx),
    .wdata ({wr_ptr, wr_chk}),
    .re    (rd_en),
    .raddr (rd_idx),
    .rdata (rd_entry)
  );

  flow_dir_valid #(.AW(IDX_W)) u_valid (
    .clk     (clk),
    .rst     (rst),
    .set_en  (wr_en),
    .set_idx (cur_idx),
    .clr_en  (inv_valid),
    .clr_idx (inv_idx),
    .q_idx   (cur_idx),
    .q_valid (slot_valid)
  );

  flow_dir_ctrl #(.IDX_W(IDX_W), .CHK_W(CHK_W), .PTR_W(PTR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .key_valid  (key_valid),
    .key_ready  (key_ready),
    .key_idx    (key_idx),
    .key_chk    (key_chk),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_kind   (kind),
    .rsp_ptr    (rsp_ptr),
    .alloc_req  (alloc_req),
    .alloc_ack  (alloc_ack),
    .alloc_full (alloc_full),
    .alloc_ptr  (alloc_ptr),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .rd_ptr     (rd_entry[ENTRY_W-1:CHK_W]),
    .rd_chk     (rd_entry[CHK_W-1:0]),
    .slot_valid (slot_valid),
    .cur_idx    (cur_idx),
    .wr_en      (wr_en),
    .wr_ptr     (wr_ptr),
    .wr_chk     (wr_chk)
  );
endmodule

// File: rtl/flow_dir_checker.sv
module flow_dir_checker #(
  parameter int IDX_W = 8,
  parameter int CHK_W = 45,
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             key_valid,
  input logic             key_ready,
  input logic [IDX_W-1:0] key_idx,
  input logic [CHK_W-1:0] key_chk,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_kind,
  input logic [PTR_W-1:0] rsp_ptr,
  input logic             alloc_req,
  input logic             alloc_ack,
  input logic             alloc_full,
  input logic [PTR_W-1:0] alloc_ptr,
  input logic             inv_valid,
  input logic [IDX_W-1:0] inv_idx
);
  // R2: an accepted key blocks further keys
  a_r2_single_flight: assert property (@(posedge clk) disable iff (rst)
    key_valid && key_ready |=> !key_ready);

  // R2: never idle while a response is pending
  a_r2_busy_while_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !key_ready);

  // R8: allocation request holds until acknowledged
  a_r8_alloc_hold: assert property (@(posedge clk) disable iff (rst)
    alloc_req && !alloc_ack |=> alloc_req);

  // R8: response holds until taken
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_ptr));

  // R3: granted pointer is returned as a new flow
  a_r3_new_ptr: assert property (@(posedge clk) disable iff (rst)
    alloc_req && alloc_ack && !alloc_full |=>
      rsp_valid && rsp_kind == 2'd1 && rsp_ptr == $past(alloc_ptr));

  // R6: refused allocation gives a full drop with null pointer
  a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
    alloc_req && alloc_ack && alloc_full |=>
      rsp_valid && rsp_kind == 2'd3 && rsp_ptr == '0);

  // R4 R5: no allocation while a response is out
  a_r4_no_alloc_in_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !alloc_req);
endmodule

bind flow_dir_lookup flow_dir_checker #(
  .IDX_W(IDX_W), .CHK_W(CHK_W), .PTR_W(PTR_W)
) u_chk (.*);

// File: tb/flow_dir_lookup_bench.sv
module flow_dir_lookup_bench;
  localparam int IDX_W = 8;
  localparam int CHK_W = 45;
  localparam int PTR_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             key_valid = 1'b0;
  logic             key_ready;
  logic [IDX_W-1:0] key_idx = '0;
  logic [CHK_W-1:0] key_chk = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b0;
  logic [1:0]       rsp_kind;
  logic [PTR_W-1:0] rsp_ptr;
  logic             alloc_req;
  logic             alloc_ack = 1'b0;
  logic             alloc_full = 1'b0;
  logic [PTR_W-1:0] alloc_ptr = '0;
  logic             inv_valid = 1'b0;
  logic [IDX_W-1:0] inv_idx = '0;

  int checks = 0;
  int errors = 0;
  logic deny = 1'b0;
  logic [PTR_W-1:0] next_ptr = 16'd100;
  int alloc_wait = 0;

  always #2 clk = ~clk;

  flow_dir_lookup #(.IDX_W(IDX_W), .CHK_W(CHK_W), .PTR_W(PTR_W)) u_flow_dir_lookup (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_ready(key_ready),
    .key_idx(key_idx), .key_chk(key_chk), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_ptr(rsp_ptr),
    .alloc_req(alloc_req), .alloc_ack(alloc_ack), .alloc_full(alloc_full),
    .alloc_ptr(alloc_ptr), .inv_valid(inv_valid), .inv_idx(inv_idx)
  );

  // Allocator model: answers on the second cycle of a request.
  initial begin
    forever begin
      @(negedge clk);
      alloc_ack = 1'b0;
      if (alloc_req && !rst) begin
        alloc_wait++;
        if (alloc_wait == 2) begin
          alloc_ack  = 1'b1;
          alloc_full = deny;
          alloc_ptr  = deny ? 16'hDEAD : next_ptr;
          if (!deny) next_ptr++;
          alloc_wait = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [IDX_W-1:0] idx, input logic [CHK_W-1:0] c,
                        input logic dn, input logic [1:0] ek,
                        input logic [PTR_W-1:0] ep, input string req);
    int n;
    deny = dn;
    @(negedge clk);
    key_valid = 1'b1; key_idx = idx; key_chk = c;
    @(negedge clk);
    key_valid = 1'b0;
    chk(key_ready == 1'b0, "R2 busy after accept", 64'(key_ready), 64'd0);
    n = 0;
    while (!rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, {req, " response"}, 64'(rsp_valid), 64'd1);
    chk(rsp_kind == ek, {req, " kind"}, 64'(rsp_kind), 64'(ek));
    chk(rsp_ptr == ep, {req, " ptr"}, 64'(rsp_ptr), 64'(ep));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(key_ready == 1'b1 && rsp_valid == 1'b0, "R2 idle after response",
        64'({key_ready, rsp_valid}), 64'h2);
    deny = 1'b0;
  endtask

  task automatic invalidate(input logic [IDX_W-1:0] idx);
    @(negedge clk);
    inv_valid = 1'b1; inv_idx = idx;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  typedef struct packed {
    logic             op;    // 0 lookup, 1 invalidate
    logic [IDX_W-1:0] idx;
    logic [CHK_W-1:0] c;
    logic             dn;
    logic [1:0]       kind;
    logic [PTR_W-1:0] ptr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd5,   45'h01A2B3C4D5E6, 1'b0, 2'd1, 16'd100}, // R3 install
    '{1'b0, 8'd5,   45'h01A2B3C4D5E6, 1'b0, 2'd0, 16'd100}, // R4 hit
    '{1'b0, 8'd5,   45'h00F0F0F0F0F0, 1'b0, 2'd2, 16'd0},   // R5 collide
    '{1'b0, 8'd5,   45'h01A2B3C4D5E6, 1'b0, 2'd0, 16'd100}, // R5 kept
    '{1'b0, 8'd9,   45'h0123456789AB, 1'b1, 2'd3, 16'd0},   // R6 full
    '{1'b0, 8'd9,   45'h0123456789AB, 1'b0, 2'd1, 16'd101}, // R6 nothing written
    '{1'b0, 8'd9,   45'h0123456789AB, 1'b0, 2'd0, 16'd101}, // R4
    '{1'b1, 8'd5,   45'h0,            1'b0, 2'd0, 16'd0},   // R7 clear
    '{1'b0, 8'd5,   45'h00F0F0F0F0F0, 1'b0, 2'd1, 16'd102}, // R7 reinstall
    '{1'b0, 8'd9,   45'h0123456789AB, 1'b0, 2'd0, 16'd101}, // R7 others kept
    '{1'b0, 8'd9,   45'h1123456789AB, 1'b0, 2'd2, 16'd0},   // R9 top bit
    '{1'b0, 8'd255, 45'h0,            1'b0, 2'd1, 16'd103}, // R3 top index
    '{1'b0, 8'd255, 45'h0,            1'b0, 2'd0, 16'd103}, // R4
    '{1'b0, 8'd0,   45'h1FFFFFFFFFFF, 1'b0, 2'd1, 16'd104}, // R3 index 0
    '{1'b0, 8'd0,   45'h1FFFFFFFFFFF, 1'b0, 2'd0, 16'd104}  // R4
  };

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(key_ready == 1'b1, "R1 key_ready", 64'(key_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(alloc_req == 1'b0, "R1 alloc_req", 64'(alloc_req), 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op)
        invalidate(VECS[i].idx);
      else
        lookup(VECS[i].idx, VECS[i].c, VECS[i].dn, VECS[i].kind, VECS[i].ptr,
               $sformatf("R3-R9 vector %0d", i));
    end

    // R8: response held while rsp_ready stays low
    deny = 1'b0;
    @(negedge clk);
    key_valid = 1'b1; key_idx = 8'd20; key_chk = 45'h0000000ABCDE;
    @(negedge clk);
    key_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_kind == 2'd1 && rsp_ptr == 16'd105, "R8 rsp hold",
          64'({rsp_valid, rsp_kind, rsp_ptr}), 64'({1'b1, 2'd1, 16'd105}));
      chk(key_ready == 1'b0, "R2 blocked while rsp pending", 64'(key_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    lookup(8'd20, 45'h0000000ABCDE, 1'b0, 2'd0, 16'd105, "R4 after held rsp");

    // R1: reset clears every slot
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(key_ready == 1'b1 && rsp_valid == 1'b0, "R1 after reset",
        64'({key_ready, rsp_valid}), 64'h2);
    lookup(8'd9, 45'h0123456789AB, 1'b0, 2'd1, 16'd106, "R1 slot cleared");
    lookup(8'd9, 45'h0123456789AB, 1'b0, 2'd0, 16'd106, "R4 after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule